// File: doc/BRIEF.md
# Software-Driven SPI Transaction Engine

This block lets software run any SPI flash transaction by hand. Each chip select has a control register and a data window. The register picks the manual (user) mode and the number of data lines, and it holds the chip select through a stop bit. Writes to the window shift bytes out on the SPI pins. Reads from the window clock bytes in and return them on the bus.

A transaction runs like this. Software puts the chip select in user mode with the stop bit set, then clears the stop bit to assert the select. It writes the opcode, address and dummy bytes on a single line. It then changes the lane-count bits, without releasing the select, and moves the data on one, two or four lines. Setting the stop bit again ends the transaction. A window write is posted: the bus is released at once while the bytes shift out. A window read holds the bus until every requested byte has arrived.

The serial clock idles low. Output data changes while SCLK is low and stays steady while SCLK is high. Input data is sampled on the rising SCLK edge, so it must be stable from just before that edge until just after it. Each SCLK half-period lasts `HALF_DIV` system clocks.

Top module: `spi_user_engine`

## Requirements
- R1: After reset every control register reads 0x0000_0004 (stop set, mode 00). All cs_n are high, sclk is low and io_oe is 0.
- R2: cs_n[i] goes low when control register i holds mode bits [1:0]=11 with stop bit 2 clear. It goes high in every other case, except while a byte for that select is being shifted. SCLK only toggles while the selected cs_n is low.
- R3: A byte write in single-lane mode gives 8 SCLK rising edges, most significant bit first, on io[0]. io_oe is 0001 and io_out is steady while SCLK is high.
- R4: A 32-bit window write (bus_word=1) sends 4 bytes, starting with bits [7:0]. A byte write (bus_word=0) sends bits [7:0] only. Writes are acknowledged before the first SCLK edge. bus_ack is a single-cycle pulse.
- R5: Control bit 30 selects four lanes and bit 29 selects two lanes. Bit 30 wins when both are set. Two lanes take 4 edges per byte on io[1:0], bits 7:6 first, with io[1] carrying the higher bit. Four lanes take 2 edges on io[3:0], high nibble first.
- R6: A window read holds off bus_ack until all requested bytes are in. In single-lane mode it samples io[1] while driving io[0] low with io_oe=0001. A byte read returns its byte in [7:0]. A word read returns the first byte in [7:0].
- R7: During a two- or four-lane read, io_oe is 0000.
- R8: If the stop bit is set while a posted write is shifting, the current byte finishes and any remaining queued bytes are dropped. cs_n then goes high.
- R9: A window access to a select whose cs_n is high, or whose mode is not 11, is acknowledged with no SCLK activity. A read in that case returns 0.
- R10: A new lane count written between window accesses takes effect from the next byte. cs_n stays low throughout.
- R11: A window access that arrives while the engine is still shifting a posted write waits until that write has finished.
- R12: Control registers keep only bits 30, 29 and 2:0. All other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 1 = data window, 0 = control register |
| bus_cs | input | CS_W | Chip-select index of the access |
| bus_word | input | 1 | Window size: 1 = 32-bit, 0 = byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle completion pulse |
| cs_n | output | NUM_CS | Active-low chip selects |
| sclk | output | 1 | Serial clock, idle low |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
Some properties are checked on every cycle:
- SCLK never toggles while the owning chip select is high.
- A chip select never rises in the middle of a byte.
- Output data stays steady while SCLK is high.
- No line is driven during a multi-lane read.
- The acknowledge is a single pulse and never comes early on a pending read.

Other behaviours can only be shown by the directed scenarios, because each needs a flash-side model to rebuild bytes from the pins:
- The bit and nibble ordering and the byte order of word accesses.
- The lane-count switch inside one transaction.
- Dropping queued bytes on a late stop.
- Ignoring accesses to an inactive select.
- The wait of a second access behind a posted write.

// File: rtl/spi_user_pkg.sv
package spi_user_pkg;

  typedef enum logic [1:0] {
    LANE_1 = 2'd0,
    LANE_2 = 2'd1,
    LANE_4 = 2'd2
  } lane_e;

  localparam logic [31:0] CTRL_RESET = 32'h0000_0004;
  localparam logic [31:0] CTRL_KEEP  = 32'h6000_0007;

  // ctl = {stop, mode[1:0]}
  function automatic logic user_live(input logic [2:0] ctl);
    return (ctl[1:0] == 2'b11) && !ctl[2];
  endfunction

  // sel = {quad, dual}; quad has priority
  function automatic lane_e lane_pick(input logic [1:0] sel);
    if (sel[1]) return LANE_4;
    if (sel[0]) return LANE_2;
    return LANE_1;
  endfunction

endpackage

// File: rtl/spi_user_regs.sv
module spi_user_regs
  import spi_user_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int CS_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [CS_W-1:0]            wr_idx,
  input  logic [31:0]                wr_data,
  input  logic [NUM_CS-1:0]          hold,
  output logic [NUM_CS-1:0][31:0]    ctrl_q,
  output logic [NUM_CS-1:0]          cs_n
);

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[gi] <= CTRL_RESET;
      end else if (wr_en && (wr_idx == CS_W'(gi))) begin
        ctrl_q[gi] <= wr_data & CTRL_KEEP;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cs_n[gi] <= 1'b1;
      end else begin
        cs_n[gi] <= !(user_live(ctrl_q[gi][2:0]) || hold[gi]);
      end
    end
  end

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_user_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  lane_e      lane,
  input  logic       rd_mode,
  input  logic [3:0] io_in,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);

  localparam int HC_W = $clog2(HALF_DIV + 1);

  logic [7:0]      sh;
  logic [7:0]      rx_sh;
  logic [2:0]      grp;
  logic [HC_W-1:0] hc;
  logic            ph;
  lane_e           lane_q;
  logic            rd_q;
  logic [7:0]      sh_next;

  function automatic logic [3:0] lead(input logic [7:0] v, input lane_e l);
    case (l)
      LANE_2:  return {2'b00, v[7:6]};
      LANE_4:  return v[7:4];
      default: return {3'b000, v[7]};
    endcase
  endfunction

  function automatic logic [7:0] advance(input logic [7:0] v, input lane_e l);
    case (l)
      LANE_2:  return {v[5:0], 2'b00};
      LANE_4:  return {v[3:0], 4'b0000};
      default: return {v[6:0], 1'b0};
    endcase
  endfunction

  function automatic logic [7:0] gather(input logic [7:0] acc, input logic [3:0] pins,
                                        input lane_e l);
    case (l)
      LANE_2:  return {acc[5:0], pins[1:0]};
      LANE_4:  return {acc[3:0], pins};
      default: return {acc[6:0], pins[1]};
    endcase
  endfunction

  function automatic logic [2:0] groups_of(input lane_e l);
    case (l)
      LANE_2:  return 3'd3;
      LANE_4:  return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [3:0] enables(input lane_e l, input logic rd);
    if (rd) return (l == LANE_1) ? 4'b0001 : 4'b0000;
    case (l)
      LANE_2:  return 4'b0011;
      LANE_4:  return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  assign sh_next = advance(sh, lane_q);
  assign rx_byte = rx_sh;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      io_out <= '0;
      io_oe  <= '0;
      sh     <= '0;
      rx_sh  <= '0;
      grp    <= '0;
      hc     <= '0;
      ph     <= 1'b0;
      lane_q <= LANE_1;
      rd_q   <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      sclk   <= 1'b0;
      sh     <= tx_byte;
      rx_sh  <= '0;
      grp    <= groups_of(lane);
      hc     <= '0;
      ph     <= 1'b0;
      lane_q <= lane;
      rd_q   <= rd_mode;
      io_out <= rd_mode ? 4'b0000 : lead(tx_byte, lane);
      io_oe  <= enables(lane, rd_mode);
    end else if (busy) begin
      if (hc == HC_W'(HALF_DIV - 1)) begin
        hc <= '0;
        if (!ph) begin
          sclk  <= 1'b1;
          ph    <= 1'b1;
          rx_sh <= gather(rx_sh, io_in, lane_q);
        end else begin
          sclk <= 1'b0;
          ph   <= 1'b0;
          if (grp == 3'd0) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            io_out <= '0;
            io_oe  <= '0;
          end else begin
            grp    <= grp - 3'd1;
            sh     <= sh_next;
            io_out <= rd_q ? 4'b0000 : lead(sh_next, lane_q);
          end
        end
      end else begin
        hc <= hc + HC_W'(1);
      end
    end
  end

  // R3: output lines hold still across the high half of SCLK
  p_data_steady_r3: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(io_out));

endmodule

// File: rtl/spi_user_engine.sv
module spi_user_engine
  import spi_user_pkg::*;
#(
  parameter int NUM_CS   = 3,
  parameter int HALF_DIV = 2,
  localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_win,
  input  logic [CS_W-1:0]   bus_cs,
  input  logic              bus_word,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic [NUM_CS-1:0] cs_n,
  output logic              sclk,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  typedef enum logic {ST_IDLE, ST_RUN} eng_e;

  eng_e                    state;
  logic [NUM_CS-1:0][31:0] ctrl_q;
  logic [NUM_CS-1:0]       hold;
  logic [31:0]             q_data;
  logic [1:0]              q_left;
  logic [1:0]              q_idx;
  logic                    q_read;
  logic [CS_W-1:0]         q_cs;
  logic [31:0]             rx_word;
  logic [31:0]             rx_merged;

  logic                    sh_start;
  logic [7:0]              sh_tx;
  lane_e                   sh_lane;
  logic                    sh_rd;
  logic                    sh_busy;
  logic                    sh_done;
  logic [7:0]              sh_rx;

  logic                    can_take;
  logic                    cs_valid;
  logic [31:0]             ctrl_sel;
  logic                    reg_acc;
  logic                    reg_we;
  logic                    win_acc;
  logic                    win_live;
  logic                    owner_live;

  assign can_take   = bus_req && !bus_ack;
  assign cs_valid   = int'(bus_cs) < NUM_CS;
  assign ctrl_sel   = cs_valid ? ctrl_q[bus_cs] : 32'h0;
  assign reg_acc    = can_take && !bus_win;
  assign reg_we     = reg_acc && bus_we && cs_valid;
  assign win_acc    = can_take && bus_win && (state == ST_IDLE);
  assign win_live   = cs_valid && !cs_n[bus_cs] && (ctrl_sel[1:0] == 2'b11);
  assign owner_live = user_live(ctrl_q[q_cs][2:0]);
  assign rx_merged  = rx_word | (32'(sh_rx) << {q_idx, 3'b000});

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_hold
    assign hold[gi] = (state == ST_RUN) && (q_cs == CS_W'(gi));
  end

  spi_user_regs #(
    .NUM_CS (NUM_CS),
    .CS_W   (CS_W)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_we),
    .wr_idx  (bus_cs),
    .wr_data (bus_wdata),
    .hold    (hold),
    .ctrl_q  (ctrl_q),
    .cs_n    (cs_n)
  );

  spi_shift_unit #(
    .HALF_DIV (HALF_DIV)
  ) shift_i (
    .clk     (clk),
    .rst     (rst),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .lane    (sh_lane),
    .rd_mode (sh_rd),
    .io_in   (io_in),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sclk    (sclk),
    .io_out  (io_out),
    .io_oe   (io_oe)
  );

  always_ff @(posedge clk) begin
    bus_ack  <= 1'b0;
    sh_start <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      bus_rdata <= '0;
      q_data    <= '0;
      q_left    <= '0;
      q_idx     <= '0;
      q_read    <= 1'b0;
      q_cs      <= '0;
      rx_word   <= '0;
      sh_tx     <= '0;
      sh_lane   <= LANE_1;
      sh_rd     <= 1'b0;
    end else begin
      if (reg_acc) begin
        bus_ack   <= 1'b1;
        bus_rdata <= bus_we ? 32'h0 : ctrl_sel;
      end
      case (state)
        ST_IDLE: begin
          if (win_acc) begin
            if (!win_live) begin
              bus_ack   <= 1'b1;
              bus_rdata <= 32'h0;
            end else begin
              state    <= ST_RUN;
              q_cs     <= bus_cs;
              q_read   <= !bus_we;
              q_data   <= bus_wdata >> 8;
              q_left   <= bus_word ? 2'd3 : 2'd0;
              q_idx    <= 2'd0;
              rx_word  <= '0;
              sh_start <= 1'b1;
              sh_tx    <= bus_wdata[7:0];
              sh_lane  <= lane_pick(ctrl_sel[30:29]);
              sh_rd    <= !bus_we;
              if (bus_we) begin
                bus_ack   <= 1'b1;
                bus_rdata <= 32'h0;
              end
            end
          end
        end
        default: begin
          if (sh_done) begin
            rx_word <= rx_merged;
            if ((q_left == 2'd0) || !owner_live) begin
              state <= ST_IDLE;
              if (q_read) begin
                bus_ack   <= 1'b1;
                bus_rdata <= rx_merged;
              end
            end else begin
              sh_start <= 1'b1;
              sh_tx    <= q_data[7:0];
              q_data   <= q_data >> 8;
              q_left   <= q_left - 2'd1;
              q_idx    <= q_idx + 2'd1;
              sh_lane  <= lane_pick(ctrl_q[q_cs][30:29]);
            end
          end
        end
      endcase
    end
  end

  // R2: the serial clock runs only under an asserted select
  p_sclk_under_cs_r2: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n[q_cs]);

  // R8: a select never drops in the middle of a byte
  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_chk
    p_cs_release_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n[gi]) |-> !sh_busy);
  end

  // R4: completion is a single-cycle pulse
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // R7: no line is driven during a multi-lane read
  p_read_float_r7: assert property (@(posedge clk) disable iff (rst)
    (sh_busy && sh_rd && (sh_lane != LANE_1)) |-> (io_oe == 4'b0000));

  // R6: a pending window read is not acknowledged early
  p_read_stall_r6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RUN) && q_read && !sh_done) |-> !bus_ack);

endmodule

// File: tb/spi_user_engine_tb.sv
module spi_user_engine_tb_top;

  localparam int NUM_CS = 3;
  localparam int CS_W   = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              bus_req, bus_we, bus_win, bus_word;
  logic [CS_W-1:0]   bus_cs;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              bus_ack;
  logic [NUM_CS-1:0] cs_n;
  logic              sclk;
  logic [3:0]        io_out, io_oe, io_in;

  int checks = 0;
  int errors = 0;

  spi_user_engine #(.NUM_CS(NUM_CS), .HALF_DIV(2)) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_win(bus_win),
    .bus_cs(bus_cs), .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in)
  );

  always #10 clk = ~clk;

  // flash-side model: logs each rising SCLK edge and serves read data
  int         rise_cnt = 0;
  int         cs_bad = 0;
  int         rd_base = 0;
  int         rd_lanes = 1;
  logic [7:0] rd_bytes [0:3];
  logic [3:0] lg_out [0:63];
  logic [3:0] lg_oe  [0:63];

  always @(posedge sclk) begin
    if (rise_cnt < 64) begin
      lg_out[rise_cnt] = io_out;
      lg_oe[rise_cnt]  = io_oe;
    end
    if (cs_n[0]) cs_bad = cs_bad + 1;
    rise_cnt = rise_cnt + 1;
  end

  always @* begin
    int g, gpb, b, sub;
    logic [7:0] v;
    logic [3:0] bits;
    g    = rise_cnt - rd_base;
    gpb  = 8 / rd_lanes;
    b    = (g / gpb) & 3;
    sub  = g % gpb;
    v    = rd_bytes[b];
    bits = 4'((v << (rd_lanes * sub)) >> (8 - rd_lanes));
    if (rd_lanes == 1) io_in = {2'b00, bits[0], 1'b0};
    else               io_in = bits;
  end

  function automatic logic [7:0] sent_byte(input int b, input int lanes);
    logic [7:0] v = '0;
    int gpb = 8 / lanes;
    for (int g = 0; g < gpb; g++) begin
      v = 8'((v << lanes) | (lg_out[b * gpb + g] & 4'((1 << lanes) - 1)));
    end
    return v;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    rise_cnt = 0;
    cs_bad   = 0;
    rd_base  = 0;
  endtask

  task automatic bus_op(input logic win, input logic we, input logic word,
                        input logic [CS_W-1:0] cs, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_win = win; bus_word = word;
    bus_cs = cs; bus_wdata = wd;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (bus_ack) break;
    end
    rd = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic reg_wr(input logic [CS_W-1:0] cs, input logic [31:0] v);
    logic [31:0] d;
    bus_op(1'b0, 1'b1, 1'b1, cs, v, d);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < NUM_CS; i++) begin
      bus_op(1'b0, 1'b0, 1'b1, CS_W'(i), 32'h0, d);
      chk(d == 32'h4, "R1 ctrl reset", d, 32'h4);
    end
    chk(cs_n == 3'b111 && !sclk && io_oe == 4'h0, "R1 pins idle",
        {cs_n, sclk, io_oe}, {3'b111, 1'b0, 4'h0});
  endtask

  task automatic t_select_and_mask();
    logic [31:0] d;
    reg_wr(0, 32'h3);
    settle(3);
    chk(cs_n == 3'b110, "R2 cs0 asserted only", cs_n, 3'b110);
    reg_wr(2, 32'hFFFF_FFFF);
    bus_op(1'b0, 1'b0, 1'b1, 2, 32'h0, d);
    chk(d == 32'h6000_0007, "R12 mask", d, 32'h6000_0007);
    settle(3);
    chk(cs_n[2] == 1'b1, "R2 stop keeps cs2 high", cs_n[2], 1'b1);
    reg_wr(2, 32'h4);
  endtask

  task automatic t_byte_single();
    logic [31:0] d;
    clear_log();
    bus_op(1'b1, 1'b1, 1'b0, 0, 32'hFFFF_FFA5, d);
    settle(200);
    chk(rise_cnt == 8, "R3 eight edges", rise_cnt, 8);
    chk(sent_byte(0, 1) == 8'hA5, "R3 msb first", sent_byte(0, 1), 8'hA5);
    chk(lg_oe[3] == 4'b0001 && cs_bad == 0, "R3 oe single", lg_oe[3], 4'b0001);
  endtask

  task automatic t_word_single();
    logic [31:0] d;
    clear_log();
    bus_op(1'b1, 1'b1, 1'b1, 0, 32'h4433_2211, d);
    chk(rise_cnt == 0, "R4 posted ack", rise_cnt, 0);
    settle(400);
    chk(rise_cnt == 32, "R4 word edges", rise_cnt, 32);
    chk({sent_byte(3,1), sent_byte(2,1), sent_byte(1,1), sent_byte(0,1)} == 32'h4433_2211,
        "R4 byte order", {sent_byte(3,1), sent_byte(2,1), sent_byte(1,1), sent_byte(0,1)},
        32'h4433_2211);
  endtask

  task automatic t_multi_lane_write();
    logic [31:0] d;
    reg_wr(0, 32'h2000_0003);
    clear_log();
    bus_op(1'b1, 1'b1, 1'b0, 0, 32'h9C, d);
    settle(200);
    chk(rise_cnt == 4 && sent_byte(0, 2) == 8'h9C, "R5 dual write",
        sent_byte(0, 2), 8'h9C);
    chk(lg_oe[0] == 4'b0011, "R5 dual oe", lg_oe[0], 4'b0011);
    reg_wr(0, 32'h6000_0003);
    clear_log();
    bus_op(1'b1, 1'b1, 1'b0, 0, 32'h5E, d);
    settle(200);
    chk(rise_cnt == 2 && sent_byte(0, 4) == 8'h5E, "R5 quad priority write",
        sent_byte(0, 4), 8'h5E);
    chk(lg_oe[1] == 4'b1111, "R5 quad oe", lg_oe[1], 4'b1111);
    reg_wr(0, 32'h3);
  endtask

  task automatic t_single_read();
    logic [31:0] d;
    clear_log();
    rd_lanes = 1; rd_bytes[0] = 8'hC3;
    bus_op(1'b1, 1'b0, 1'b0, 0, 32'h0, d);
    chk(d == 32'hC3, "R6 single read data", d, 32'hC3);
    chk(rise_cnt == 8, "R6 ack after all bits", rise_cnt, 8);
    chk(lg_oe[5] == 4'b0001 && lg_out[5] == 4'h0, "R6 io0 driven low",
        {lg_oe[5], lg_out[5]}, 8'h10);
  endtask

  task automatic t_quad_read();
    logic [31:0] d;
    reg_wr(0, 32'h4000_0003);
    clear_log();
    rd_lanes = 4;
    rd_bytes[0] = 8'h12; rd_bytes[1] = 8'h34; rd_bytes[2] = 8'h56; rd_bytes[3] = 8'h78;
    bus_op(1'b1, 1'b0, 1'b1, 0, 32'h0, d);
    chk(d == 32'h7856_3412, "R6 quad word read", d, 32'h7856_3412);
    chk(rise_cnt == 8 && lg_oe[2] == 4'h0 && lg_oe[7] == 4'h0, "R7 lines released",
        lg_oe[2], 4'h0);
    reg_wr(0, 32'h3);
  endtask

  task automatic t_late_stop();
    logic [31:0] d;
    clear_log();
    bus_op(1'b1, 1'b1, 1'b1, 0, 32'hDEAD_BEEF, d);
    reg_wr(0, 32'h7);
    settle(400);
    chk(rise_cnt == 8, "R8 only current byte", rise_cnt, 8);
    chk(sent_byte(0, 1) == 8'hEF && cs_bad == 0, "R8 byte intact", sent_byte(0, 1), 8'hEF);
    chk(cs_n[0] == 1'b1, "R8 cs released", cs_n[0], 1'b1);
  endtask

  task automatic t_inactive();
    logic [31:0] d;
    clear_log();
    bus_op(1'b1, 1'b1, 1'b1, 0, 32'h1234_5678, d);
    bus_op(1'b1, 1'b0, 1'b1, 0, 32'h0, d);
    settle(100);
    chk(rise_cnt == 0 && d == 32'h0, "R9 stopped cs ignored", {rise_cnt[15:0], d[15:0]}, 32'h0);
    reg_wr(1, 32'h0);
    bus_op(1'b1, 1'b1, 1'b0, 1, 32'hAA, d);
    settle(100);
    chk(rise_cnt == 0 && cs_n[1], "R9 non-user cs ignored", rise_cnt, 0);
  endtask

  task automatic t_phase_switch();
    logic [31:0] d;
    reg_wr(0, 32'h3);
    clear_log();
    bus_op(1'b1, 1'b1, 1'b0, 0, 32'h6B, d);
    settle(100);
    reg_wr(0, 32'h4000_0003);
    settle(3);
    chk(cs_n[0] == 1'b0, "R10 cs held across switch", cs_n[0], 1'b0);
    rd_base = rise_cnt; rd_lanes = 4; rd_bytes[0] = 8'hA7;
    bus_op(1'b1, 1'b0, 1'b0, 0, 32'h0, d);
    chk(sent_byte(0, 1) == 8'h6B && d == 32'hA7, "R10 opcode then quad data",
        d, 32'hA7);
    chk(rise_cnt == 10 && cs_bad == 0, "R10 edge count", rise_cnt, 10);
    reg_wr(0, 32'h3);
  endtask

  task automatic t_back_to_back();
    logic [31:0] d;
    clear_log();
    bus_op(1'b1, 1'b1, 1'b1, 0, 32'h0403_0201, d);
    bus_op(1'b1, 1'b1, 1'b0, 0, 32'h77, d);
    chk(rise_cnt == 32, "R11 second waits", rise_cnt, 32);
    settle(200);
    chk(rise_cnt == 40 && sent_byte(4, 1) == 8'h77, "R11 second byte sent",
        sent_byte(4, 1), 8'h77);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bus_req = 0; bus_we = 0; bus_win = 0; bus_word = 0; bus_cs = '0; bus_wdata = '0;
    rd_bytes[0] = 0; rd_bytes[1] = 0; rd_bytes[2] = 0; rd_bytes[3] = 0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle(2);
    t_reset();
    t_select_and_mask();
    t_byte_single();
    t_word_single();
    t_multi_lane_write();
    t_single_read();
    t_quad_read();
    t_late_stop();
    t_inactive();
    t_phase_switch();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule